// File: doc/BRIEF.md
# Thirty-Two-Pin GPIO with Dual Interrupt Banks

This block is a general-purpose I/O port with 32 pins and a word-wide register interface. Each pin is either an input or a driven output. Input pins can raise events on a rising edge, a falling edge, a high level or a low level, in any combination per pin. Every event sets the pin's bit in two independent interrupt banks. Each bank has its own write-one-to-clear status register, its own enable register and its own interrupt line, so two consumers can service the same pins separately.

Set and clear alias offsets let software change single bits of the output data, either enable register or the wakeup enable without a read-modify-write. A system configuration register qualifies a one-cycle wakeup request. A write with bit 1 set performs a soft reset. Debounce settings are stored and read back but have no effect on detection.

The register port is a simple synchronous bus. A write takes effect at the clock edge where `bus_wr` is high. Read data is a combinational function of `bus_addr` and of the current register state. Pin inputs are expected to be synchronous to `clk` already.

Top module: `gpio_dual_irq`

## Requirements
- R1: After reset, output enable (0x34) reads 0xFFFFFFFF (all pins inputs), ctrl (0x30) reads 2, revision (0x00) reads 0x18, sysstatus (0x14) reads 1, and both status registers, both enables, wakeup enable, level/edge selects and debounce registers read 0; `irq_o` is 0.
- R2: Writes to offsets 0x00, 0x14 and 0x38 have no effect. Data-in (0x38) returns `pin_in` as sampled at the previous clock edge.
- R3: `pin_out` carries the data-out register (0x3C). `pin_drive` bit n is 1 exactly when output-enable bit n is 0.
- R4: A write to 0x94 sets the data-out bits written as 1, and a write to 0x90 clears them. Other bits are kept. A read of either alias returns data-out.
- R5: On a pin whose output-enable bit is 1, a 0→1 change with the rising-select bit (0x48) set, or a 1→0 change with the falling-select bit (0x4C) set, sets that pin's bit in both status registers (0x18 and 0x28). The bit is visible after the first clock edge that sees the change. An edge on a pin with output-enable 0 sets nothing.
- R6: While an input pin is high with its high-level bit (0x44) set, or low with its low-level bit (0x40) set, its status bit in both banks is set every cycle. A status clear of such a bit does not stick.
- R7: Writing 1s to a status register clears those bits in that bank only. Writing 0s leaves bits unchanged.
- R8: `irq_o[0]` is the OR of status 0x18 AND enable 0x1C. `irq_o[1]` is the same for 0x28 and 0x2C.
- R9: The enable aliases (bank 0 clear 0x60 / set 0x64, bank 1 clear 0x70 / set 0x74) and the wakeup enable aliases (clear 0x80 / set 0x84) clear or set only the bits written as 1. A read of an alias returns its underlying register.
- R10: A write to sysconfig (0x10) stores the value AND 0x1D. If bit 1 of the written value is set, every other register first returns to its R1 value.
- R11: Ctrl (0x30) keeps only the low 3 bits of a write.
- R12: `wake_o` pulses for one cycle after an edge event, or a newly matching level condition, on a pin whose wakeup-enable bit (0x20) is set. This happens only when sysconfig bit 2 is 1 and sysconfig bits 4:3 are not 00.
- R13: Debounce enable (0x50, 32 bits) and debounce time (0x54, low 8 bits) read back what was written. They do not change when edge events are reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for this cycle |
| bus_addr | input | 8 | Register byte offset for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pin_in | input | 32 | Pin levels, synchronous to `clk` |
| pin_out | output | 32 | Output data per pin |
| pin_drive | output | 32 | Drive enable per pin (1 = drive `pin_out`) |
| irq_o | output | 2 | Interrupt lines of bank 0 and bank 1 |
| wake_o | output | 1 | One-cycle wakeup request |

## Verification
The assertions assume that `pin_in` is already synchronous to `clk` and that a write is one cycle long and presents a word offset. Under those conditions the status banks can be checked for sticky event bits and write-one-to-clear behaviour, and the wakeup line can be checked against the configuration that held one cycle earlier. The stimulus changes pins and bus signals only at the falling edge and spaces pin changes by at least one cycle, so each edge is seen exactly once. Every level condition is removed, and the status registers are cleared, before the next scenario relies on them.

// File: rtl/gpio_dual_pkg.sv
package gpio_dual_pkg;
    localparam int DW        = 32;
    localparam int AW        = 8;
    localparam int NUM_BANKS = 2;
    localparam int BANK_STEP = 16;

    localparam logic [AW-1:0] OFS_REV      = 8'h00;
    localparam logic [AW-1:0] OFS_SYSCFG   = 8'h10;
    localparam logic [AW-1:0] OFS_SYSSTAT  = 8'h14;
    localparam logic [AW-1:0] OFS_STAT0    = 8'h18;
    localparam logic [AW-1:0] OFS_EN0      = 8'h1C;
    localparam logic [AW-1:0] OFS_WKEN     = 8'h20;
    localparam logic [AW-1:0] OFS_STAT1    = 8'h28;
    localparam logic [AW-1:0] OFS_EN1      = 8'h2C;
    localparam logic [AW-1:0] OFS_CTRL     = 8'h30;
    localparam logic [AW-1:0] OFS_OE       = 8'h34;
    localparam logic [AW-1:0] OFS_DIN      = 8'h38;
    localparam logic [AW-1:0] OFS_DOUT     = 8'h3C;
    localparam logic [AW-1:0] OFS_LVL_LO   = 8'h40;
    localparam logic [AW-1:0] OFS_LVL_HI   = 8'h44;
    localparam logic [AW-1:0] OFS_RISE     = 8'h48;
    localparam logic [AW-1:0] OFS_FALL     = 8'h4C;
    localparam logic [AW-1:0] OFS_DB_EN    = 8'h50;
    localparam logic [AW-1:0] OFS_DB_TIME  = 8'h54;
    localparam logic [AW-1:0] OFS_EN0_CLR  = 8'h60;
    localparam logic [AW-1:0] OFS_EN0_SET  = 8'h64;
    localparam logic [AW-1:0] OFS_EN1_CLR  = 8'h70;
    localparam logic [AW-1:0] OFS_EN1_SET  = 8'h74;
    localparam logic [AW-1:0] OFS_WKEN_CLR = 8'h80;
    localparam logic [AW-1:0] OFS_WKEN_SET = 8'h84;
    localparam logic [AW-1:0] OFS_DOUT_CLR = 8'h90;
    localparam logic [AW-1:0] OFS_DOUT_SET = 8'h94;

    localparam logic [7:0] REV_VALUE   = 8'h18;
    localparam logic [7:0] SYSCFG_KEEP = 8'h1D;
    localparam int         SOFTRST_BIT = 1;
    localparam int         WAKE_EN_BIT = 2;
    localparam logic [2:0] CTRL_RESET  = 3'd2;
endpackage

// File: rtl/gpio_pin_detect.sv
module gpio_pin_detect #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sreset,
    input  logic [NPINS-1:0] pin_in,
    input  logic [NPINS-1:0] is_input,
    input  logic [NPINS-1:0] rise_sel,
    input  logic [NPINS-1:0] fall_sel,
    input  logic [NPINS-1:0] low_sel,
    input  logic [NPINS-1:0] high_sel,
    output logic [NPINS-1:0] pin_q,
    output logic [NPINS-1:0] hit,
    output logic [NPINS-1:0] wake_evt
);
    logic [NPINS-1:0] edge_hit;
    logic [NPINS-1:0] lvl_hit;
    logic [NPINS-1:0] lvl_q;

    // Previous pin sample for edge detection, previous level match for wake.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q <= '0;
            lvl_q <= '0;
        end else begin
            pin_q <= pin_in;
            lvl_q <= sreset ? '0 : lvl_hit;
        end
    end

    always_comb begin
        edge_hit = is_input & ((pin_in & ~pin_q & rise_sel) |
                               (~pin_in & pin_q & fall_sel));
        lvl_hit  = is_input & ((pin_in & high_sel) | (~pin_in & low_sel));
        hit      = edge_hit | lvl_hit;
        wake_evt = edge_hit | (lvl_hit & ~lvl_q);
    end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
    parameter int         NPINS    = 32,
    parameter logic [7:0] STAT_OFS = 8'h18,
    parameter logic [7:0] EN_OFS   = 8'h1C,
    parameter logic [7:0] CLR_OFS  = 8'h60,
    parameter logic [7:0] SET_OFS  = 8'h64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sreset,
    input  logic             bus_wr,
    input  logic [7:0]       bus_addr,
    input  logic [NPINS-1:0] wr_data,
    input  logic [NPINS-1:0] hit,
    output logic [NPINS-1:0] stat_q,
    output logic [NPINS-1:0] en_q,
    output logic             irq
);
    logic wr_stat, wr_en, wr_clr, wr_set;

    assign wr_stat = bus_wr && (bus_addr == STAT_OFS);
    assign wr_en   = bus_wr && (bus_addr == EN_OFS);
    assign wr_clr  = bus_wr && (bus_addr == CLR_OFS);
    assign wr_set  = bus_wr && (bus_addr == SET_OFS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
            en_q   <= '0;
        end else if (sreset) begin
            stat_q <= '0;
            en_q   <= '0;
        end else begin
            stat_q <= (stat_q & ~(wr_stat ? wr_data : '0)) | hit;
            if (wr_en)       en_q <= wr_data;
            else if (wr_clr) en_q <= en_q & ~wr_data;
            else if (wr_set) en_q <= en_q | wr_data;
        end
    end

    assign irq = |(stat_q & en_q);

    // R5 / R6: a reported event is never lost in the cycle it arrives.
    assert_hit_sticks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !sreset |=> ((stat_q & $past(hit)) == $past(hit)))
        else $error("event bit not captured");

    // R7: written ones clear unless the same bit is hit again.
    assert_stat_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && !sreset) |=> ((stat_q & $past(wr_data) & ~$past(hit)) == '0))
        else $error("status clear ignored");

    // R9: set alias.
    assert_en_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_set && !sreset) |=> ((en_q & $past(wr_data)) == $past(wr_data)))
        else $error("enable set alias failed");

    // R9: clear alias.
    assert_en_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clr && !sreset) |=> ((en_q & $past(wr_data)) == '0))
        else $error("enable clear alias failed");
endmodule

// File: rtl/gpio_dual_irq.sv
module gpio_dual_irq
    import gpio_dual_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] pin_out,
    output logic [NPINS-1:0] pin_drive,
    output logic [NUM_BANKS-1:0] irq_o,
    output logic             wake_o
);
    localparam logic [NPINS-1:0] ALL_ONES = '1;

    logic [7:0]       cfg_q;
    logic [2:0]       ctrl_q;
    logic [NPINS-1:0] oe_q, dout_q, low_q, high_q, rise_q, fall_q, wken_q, dben_q;
    logic [7:0]       dbtime_q;
    logic [NPINS-1:0] wd;
    logic             sreset;
    logic             wake_gate;

    logic [NPINS-1:0] pin_q, hit, wake_evt;
    logic [NPINS-1:0] bank_stat [NUM_BANKS];
    logic [NPINS-1:0] bank_en   [NUM_BANKS];

    assign wd     = bus_wdata[NPINS-1:0];
    assign sreset = bus_wr && (bus_addr == OFS_SYSCFG) && bus_wdata[SOFTRST_BIT];
    assign wake_gate = cfg_q[WAKE_EN_BIT] && (cfg_q[4:3] != 2'b00);

    // Configuration and data registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q    <= '0;
            ctrl_q   <= CTRL_RESET;
            oe_q     <= ALL_ONES;
            dout_q   <= '0;
            low_q    <= '0;
            high_q   <= '0;
            rise_q   <= '0;
            fall_q   <= '0;
            wken_q   <= '0;
            dben_q   <= '0;
            dbtime_q <= '0;
        end else if (sreset) begin
            cfg_q    <= bus_wdata[7:0] & SYSCFG_KEEP;
            ctrl_q   <= CTRL_RESET;
            oe_q     <= ALL_ONES;
            dout_q   <= '0;
            low_q    <= '0;
            high_q   <= '0;
            rise_q   <= '0;
            fall_q   <= '0;
            wken_q   <= '0;
            dben_q   <= '0;
            dbtime_q <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                OFS_SYSCFG:   cfg_q    <= bus_wdata[7:0] & SYSCFG_KEEP;
                OFS_CTRL:     ctrl_q   <= bus_wdata[2:0];
                OFS_OE:       oe_q     <= wd;
                OFS_DOUT:     dout_q   <= wd;
                OFS_DOUT_CLR: dout_q   <= dout_q & ~wd;
                OFS_DOUT_SET: dout_q   <= dout_q | wd;
                OFS_LVL_LO:   low_q    <= wd;
                OFS_LVL_HI:   high_q   <= wd;
                OFS_RISE:     rise_q   <= wd;
                OFS_FALL:     fall_q   <= wd;
                OFS_WKEN:     wken_q   <= wd;
                OFS_WKEN_CLR: wken_q   <= wken_q & ~wd;
                OFS_WKEN_SET: wken_q   <= wken_q | wd;
                OFS_DB_EN:    dben_q   <= wd;
                OFS_DB_TIME:  dbtime_q <= bus_wdata[7:0];
                default: ;
            endcase
        end
    end

    // Wakeup pulse register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      wake_o <= 1'b0;
        else if (sreset) wake_o <= 1'b0;
        else             wake_o <= wake_gate && |(wake_evt & wken_q);
    end

    gpio_pin_detect #(.NPINS(NPINS)) u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .sreset   (sreset),
        .pin_in   (pin_in),
        .is_input (oe_q),
        .rise_sel (rise_q),
        .fall_sel (fall_q),
        .low_sel  (low_q),
        .high_sel (high_q),
        .pin_q    (pin_q),
        .hit      (hit),
        .wake_evt (wake_evt)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        gpio_irq_bank #(
            .NPINS    (NPINS),
            .STAT_OFS (8'(int'(OFS_STAT0)   + BANK_STEP * b)),
            .EN_OFS   (8'(int'(OFS_EN0)     + BANK_STEP * b)),
            .CLR_OFS  (8'(int'(OFS_EN0_CLR) + BANK_STEP * b)),
            .SET_OFS  (8'(int'(OFS_EN0_SET) + BANK_STEP * b))
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .sreset   (sreset),
            .bus_wr   (bus_wr),
            .bus_addr (bus_addr),
            .wr_data  (wd),
            .hit      (hit),
            .stat_q   (bank_stat[b]),
            .en_q     (bank_en[b]),
            .irq      (irq_o[b])
        );
    end

    assign pin_out   = dout_q;
    assign pin_drive = ~oe_q;

    // Read mux.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_REV:      bus_rdata = DW'(REV_VALUE);
            OFS_SYSCFG:   bus_rdata = DW'(cfg_q);
            OFS_SYSSTAT:  bus_rdata = DW'(1);
            OFS_STAT0:    bus_rdata = DW'(bank_stat[0]);
            OFS_EN0, OFS_EN0_CLR, OFS_EN0_SET:
                          bus_rdata = DW'(bank_en[0]);
            OFS_WKEN, OFS_WKEN_CLR, OFS_WKEN_SET:
                          bus_rdata = DW'(wken_q);
            OFS_STAT1:    bus_rdata = DW'(bank_stat[1]);
            OFS_EN1, OFS_EN1_CLR, OFS_EN1_SET:
                          bus_rdata = DW'(bank_en[1]);
            OFS_CTRL:     bus_rdata = DW'(ctrl_q);
            OFS_OE:       bus_rdata = DW'(oe_q);
            OFS_DIN:      bus_rdata = DW'(pin_q);
            OFS_DOUT, OFS_DOUT_CLR, OFS_DOUT_SET:
                          bus_rdata = DW'(dout_q);
            OFS_LVL_LO:   bus_rdata = DW'(low_q);
            OFS_LVL_HI:   bus_rdata = DW'(high_q);
            OFS_RISE:     bus_rdata = DW'(rise_q);
            OFS_FALL:     bus_rdata = DW'(fall_q);
            OFS_DB_EN:    bus_rdata = DW'(dben_q);
            OFS_DB_TIME:  bus_rdata = DW'(dbtime_q);
            default:      bus_rdata = '0;
        endcase
    end

    // R12: a wake pulse needs the qualifying configuration one cycle earlier.
    assert_wake_gated_R12: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> $past(cfg_q[WAKE_EN_BIT] && (cfg_q[4:3] != 2'b00)))
        else $error("wake without qualifying configuration");

    // R10: soft reset returns direction and ctrl to their reset values.
    assert_soft_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sreset |=> (oe_q == ALL_ONES && ctrl_q == CTRL_RESET && wken_q == '0))
        else $error("soft reset incomplete");
endmodule

// File: tb/tb_gpio_dual_irq.sv
module tb_gpio_dual_irq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_drive;
    logic [1:0]  irq_o;
    logic        wake_o;

    always #4 clk = ~clk;   // 125 MHz

    gpio_dual_irq dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_drive(pin_drive), .irq_o(irq_o), .wake_o(wake_o)
    );

    localparam int SEL_RD = 0, SEL_IRQ = 1, SEL_WAKE = 2, SEL_POUT = 3, SEL_DRV = 4;

    typedef struct {
        int          sel;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sbq[$];
    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // Driver: write one register.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Driver: push an expectation; it is compared after the next rising edge.
    task automatic chk(input int sel, input logic [7:0] a, input logic [31:0] e, input string tag);
        item_t it;
        bus_addr = a;
        it.sel = sel; it.exp = e; it.tag = tag;
        sbq.push_back(it);
        @(negedge clk);
    endtask

    task automatic pins(input logic [31:0] v);
        pin_in = v;
    endtask

    // Monitor: pop and compare between edges.
    initial begin
        forever begin
            item_t it;
            logic [31:0] act;
            @(posedge clk);
            #3;
            if (sbq.size() > 0) begin
                it = sbq.pop_front();
                case (it.sel)
                    SEL_RD:   act = bus_rdata;
                    SEL_IRQ:  act = {30'b0, irq_o};
                    SEL_WAKE: act = {31'b0, wake_o};
                    SEL_POUT: act = pin_out;
                    default:  act = pin_drive;
                endcase
                n_chk++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(SEL_RD, 8'h34, 32'hFFFF_FFFF, "R1 oe reset");
        chk(SEL_RD, 8'h30, 32'h2, "R1 ctrl reset");
        chk(SEL_RD, 8'h00, 32'h18, "R1 revision");
        chk(SEL_RD, 8'h14, 32'h1, "R1 sysstatus");
        chk(SEL_RD, 8'h18, 32'h0, "R1 status0 reset");
        chk(SEL_RD, 8'h2C, 32'h0, "R1 enable1 reset");
        chk(SEL_IRQ, 8'h00, 32'h0, "R1 irq reset");
        chk(SEL_DRV, 8'h00, 32'h0, "R1 no pin driven");

        // R2 read-only offsets, data-in
        wr(8'h00, 32'h55);
        chk(SEL_RD, 8'h00, 32'h18, "R2 revision write ignored");
        wr(8'h14, 32'h0);
        chk(SEL_RD, 8'h14, 32'h1, "R2 sysstatus write ignored");
        pins(32'hA5A5_0000);
        chk(SEL_RD, 8'h38, 32'hA5A5_0000, "R2 data-in");
        wr(8'h38, 32'h0);
        chk(SEL_RD, 8'h38, 32'hA5A5_0000, "R2 data-in write ignored");
        pins(32'h0);
        chk(SEL_RD, 8'h38, 32'h0, "R2 data-in low");

        // R3 drive
        wr(8'h3C, 32'h0000_F0F0);
        wr(8'h34, 32'hFFFF_00FF);
        chk(SEL_POUT, 8'h00, 32'h0000_F0F0, "R3 pin_out");
        chk(SEL_DRV, 8'h00, 32'h0000_FF00, "R3 pin_drive");

        // R4 data-out aliases
        wr(8'h94, 32'h3);
        chk(SEL_RD, 8'h94, 32'h0000_F0F3, "R4 set alias read");
        wr(8'h90, 32'h30);
        chk(SEL_RD, 8'h3C, 32'h0000_F0C3, "R4 clear alias");
        chk(SEL_POUT, 8'h00, 32'h0000_F0C3, "R4 pin_out after clear");
        wr(8'h34, 32'hFFFF_FFFF);

        // R5 edges
        wr(8'h48, 32'h1);
        wr(8'h4C, 32'h2);
        pins(32'h2);
        chk(SEL_RD, 8'h18, 32'h0, "R5 unselected rise");
        pins(32'h1);
        chk(SEL_RD, 8'h18, 32'h3, "R5 rise and fall bank0");
        chk(SEL_RD, 8'h28, 32'h3, "R5 rise and fall bank1");
        wr(8'h34, 32'hFFFF_FFFB);
        wr(8'h48, 32'h5);
        pins(32'h5);
        chk(SEL_RD, 8'h18, 32'h3, "R5 edge on output pin ignored");
        wr(8'h48, 32'h1);
        wr(8'h34, 32'hFFFF_FFFF);

        // R7 write-one-to-clear per bank
        wr(8'h18, 32'h1);
        chk(SEL_RD, 8'h18, 32'h2, "R7 clear bank0 bit0");
        chk(SEL_RD, 8'h28, 32'h3, "R7 bank1 untouched");
        wr(8'h28, 32'h3);
        chk(SEL_RD, 8'h28, 32'h0, "R7 clear bank1");
        wr(8'h18, 32'h2);
        chk(SEL_RD, 8'h18, 32'h0, "R7 clear bank0 bit1");

        // R8 interrupt lines
        wr(8'h1C, 32'h10);
        chk(SEL_IRQ, 8'h00, 32'h0, "R8 no status");
        wr(8'h48, 32'h10);
        pins(32'h15);
        chk(SEL_IRQ, 8'h00, 32'h1, "R8 bank0 only enabled");
        wr(8'h2C, 32'h10);
        chk(SEL_IRQ, 8'h00, 32'h3, "R8 both banks");
        wr(8'h18, 32'h10);
        chk(SEL_IRQ, 8'h00, 32'h2, "R8 bank1 only");

        // R9 enable and wakeup aliases
        wr(8'h70, 32'h10);
        chk(SEL_RD, 8'h2C, 32'h0, "R9 bank1 clear alias");
        chk(SEL_IRQ, 8'h00, 32'h0, "R9 irq after disable");
        wr(8'h64, 32'h81);
        chk(SEL_RD, 8'h60, 32'h91, "R9 bank0 set alias");
        wr(8'h60, 32'h10);
        chk(SEL_RD, 8'h1C, 32'h81, "R9 bank0 clear alias");
        wr(8'h84, 32'h0F);
        wr(8'h80, 32'h03);
        chk(SEL_RD, 8'h20, 32'h0C, "R9 wake enable aliases");

        // R6 level detection
        wr(8'h28, 32'hFFFF_FFFF);
        wr(8'h44, 32'h100);
        chk(SEL_RD, 8'h18, 32'h0, "R6 high-level not met");
        pins(32'h115);
        chk(SEL_RD, 8'h18, 32'h100, "R6 high level");
        wr(8'h18, 32'h100);
        chk(SEL_RD, 8'h18, 32'h100, "R6 clear does not stick");
        pins(32'h15);
        wr(8'h18, 32'h100);
        chk(SEL_RD, 8'h18, 32'h0, "R6 clear after level gone");
        wr(8'h40, 32'h200);
        chk(SEL_RD, 8'h28, 32'h300, "R6 low level bank1");
        wr(8'h40, 32'h0);
        wr(8'h44, 32'h0);
        wr(8'h18, 32'hFFFF_FFFF);
        wr(8'h28, 32'hFFFF_FFFF);
        chk(SEL_RD, 8'h28, 32'h0, "R6 levels removed");

        // R12 wakeup
        wr(8'h48, 32'h18);
        pins(32'h1D);
        chk(SEL_WAKE, 8'h00, 32'h0, "R12 wake disabled by config");
        pins(32'h15);
        chk(SEL_WAKE, 8'h00, 32'h0, "R12 idle");
        wr(8'h10, 32'h0C);
        pins(32'h1D);
        chk(SEL_WAKE, 8'h00, 32'h1, "R12 wake pulse");
        chk(SEL_WAKE, 8'h00, 32'h0, "R12 pulse one cycle");
        pins(32'h0D);
        chk(SEL_WAKE, 8'h00, 32'h0, "R12 no event");
        pins(32'h1D);
        chk(SEL_WAKE, 8'h00, 32'h0, "R12 pin without wake enable");
        wr(8'h10, 32'h04);
        pins(32'h15);
        chk(SEL_WAKE, 8'h00, 32'h0, "R12 idle mode bits zero");
        pins(32'h1D);
        chk(SEL_WAKE, 8'h00, 32'h0, "R12 no wake when bits 4:3 zero");

        // R11 ctrl, R10 sysconfig and soft reset
        wr(8'h30, 32'hFF);
        chk(SEL_RD, 8'h30, 32'h7, "R11 ctrl low bits");
        wr(8'h10, 32'hE4);
        chk(SEL_RD, 8'h10, 32'h04, "R10 sysconfig mask");
        wr(8'h34, 32'h0);
        wr(8'h10, 32'hFF);
        chk(SEL_RD, 8'h10, 32'h1D, "R10 sysconfig after soft reset");
        chk(SEL_RD, 8'h34, 32'hFFFF_FFFF, "R10 oe reset");
        chk(SEL_RD, 8'h30, 32'h2, "R10 ctrl reset");
        chk(SEL_RD, 8'h48, 32'h0, "R10 rise reset");
        chk(SEL_RD, 8'h20, 32'h0, "R10 wake enable reset");
        chk(SEL_RD, 8'h1C, 32'h0, "R10 enable0 reset");
        chk(SEL_RD, 8'h18, 32'h0, "R10 status0 reset");

        // R13 debounce storage, no effect
        wr(8'h50, 32'hDEAD_BEEF);
        chk(SEL_RD, 8'h50, 32'hDEAD_BEEF, "R13 debounce enable");
        wr(8'h54, 32'h1A5);
        chk(SEL_RD, 8'h54, 32'hA5, "R13 debounce time");
        wr(8'h48, 32'h1);
        pins(32'h1C);
        chk(SEL_RD, 8'h18, 32'h0, "R13 no event on fall");
        pins(32'h1D);
        chk(SEL_RD, 8'h18, 32'h1, "R13 edge reported without delay");

        while (sbq.size() > 0) @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule